// File: doc/BRIEF.md
# Millisecond Play-Time Counter

This block keeps the elapsed play time of an audio stream as a 24-bit count of milliseconds. A prescaler divides the system clock into a one-cycle tick every millisecond. The count advances on that tick only while the player is in play mode. It stays put while the player is paused, stopped or seeking, and it returns to zero when the player goes from stop straight into play.

A host reaches the count through three byte-wide registers. Index 0 holds the low byte and index 2 holds the high byte. A read of index 0 copies the whole count into a shadow register, so the later reads of indices 1 and 2 return bytes that belong to the same instant. Writes are staged in the same order: bytes 0 and 1 wait in staging registers, and the write of byte 2 loads all 24 bits into the counter at once.

During fast forward or rewind, the audio processor can load a new value through a separate adjust port.

Top module: `playtime_ms`

## Requirements
- R1: In play mode (mode_i = 1) the count increments by one on each millisecond tick. Ticks come exactly once every TICK_DIV clock cycles, so any run of k*TICK_DIV consecutive play cycles adds exactly k.
- R2: The count wraps from FFFFFFh to 000000h on an increment.
- R3: host_rdata returns the live low byte when host_sel = 0. A cycle with host_rd high and host_sel = 0 captures all 24 bits into the shadow. host_sel = 1 returns shadow bits 15:8 and host_sel = 2 returns shadow bits 23:16, and the shadow changes at no other time.
- R4: A write with host_sel = 0 or 1 only stages the byte and leaves the count unchanged. A write with host_sel = 2 loads {wdata, staged byte 1, staged byte 0} into the count at that clock edge.
- R5: A transition from stop (mode_i = 0) to play (mode_i = 1) clears the count to zero at the first play edge. Entering play from pause (2) or seek (3) does not clear the count.
- R6: In pause (2), stop (0) and seek (3) the count holds its value across ticks.
- R7: A cycle with adj_load high loads adj_value into the count in any mode.
- R8: If a host commit (write with host_sel = 2) and adj_load occur in the same cycle, the host value is loaded.
- R9: Both kinds of load win over the stop-to-play clear, and the clear wins over a tick in the same cycle.
- R10: After reset the count, the shadow and the staging registers are zero.
- R11: host_sel = 3 is out of range. A read there returns 0, and a write there changes neither the count nor the staging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Player mode: 0 stop, 1 play, 2 pause, 3 seek |
| host_sel | input | 2 | Byte register index |
| host_rd | input | 1 | Host read strobe (captures the shadow at index 0) |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| adj_load | input | 1 | Processor load strobe |
| adj_value | input | 24 | Value loaded by the processor |

## Verification
The counting function is tried with three patterns, and each one isolates a different fault:
- A play window that is an exact multiple of the tick period separates a correct tick rate from a wrong one.
- A start value of FFFFFFh separates a clean wrap from a carry that is lost or that spills out of the count.
- A start value of 12FFFFh, with ticks landing between the low-byte read and the upper-byte reads, separates shadowed reads from live reads.

Mode sequences tell the stop-to-play clear apart from a resume out of pause. Cycles in which commit, adjust and the clear collide pin down the priority order.

// File: rtl/playtime_pkg.sv
package playtime_pkg;
   typedef enum logic [1:0] {
      PM_STOP  = 2'd0,
      PM_PLAY  = 2'd1,
      PM_PAUSE = 2'd2,
      PM_SEEK  = 2'd3
   } play_mode_e;
endpackage

// File: rtl/pt_tick_gen.sv
module pt_tick_gen #(
   parameter int TICK_DIV = 100000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   logic tick_q;
   assign tick = tick_q;

   generate
      if (TICK_DIV == 1) begin : g_every_cycle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tick_q <= 1'b0;
            else        tick_q <= 1'b1;
         end
      end else begin : g_prescale
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q  <= '0;
               tick_q <= 1'b0;
            end else begin
               tick_q <= (pre_q == PW'(TICK_DIV - 1));
               if (pre_q == PW'(TICK_DIV - 1)) pre_q <= '0;
               else                            pre_q <= pre_q + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/pt_host_port.sv
module pt_host_port #(
   parameter int CNT_W  = 24,
   parameter int BYTE_W = 8,
   localparam int NBYTES = CNT_W / BYTE_W,
   localparam int IDX_W  = $clog2(NBYTES),
   localparam int LOW_W  = CNT_W - BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  sel,
   input  logic              rd,
   input  logic              wr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [CNT_W-1:0]  count_i,
   output logic [BYTE_W-1:0] rdata,
   output logic              commit,
   output logic [CNT_W-1:0]  commit_value,
   output logic [CNT_W-1:0]  shadow_o
);
   localparam int TOP_IDX = NBYTES - 1;

   logic [LOW_W-1:0] stage_q;
   logic [CNT_W-1:0] shadow_q;

   generate
      for (genvar b = 0; b < NBYTES - 1; b++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               stage_q[b*BYTE_W +: BYTE_W] <= '0;
            else if (wr && sel == IDX_W'(b))
               stage_q[b*BYTE_W +: BYTE_W] <= wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              shadow_q <= '0;
      else if (rd && sel == IDX_W'(0))         shadow_q <= count_i;
   end

   assign commit       = wr && (sel == IDX_W'(TOP_IDX));
   assign commit_value = {wdata, stage_q};
   assign shadow_o     = shadow_q;

   always_comb begin
      rdata = '0;
      if (sel == IDX_W'(0)) rdata = count_i[BYTE_W-1:0];
      for (int b = 1; b < NBYTES; b++) begin
         if (sel == IDX_W'(b)) rdata = shadow_q[b*BYTE_W +: BYTE_W];
      end
   end
endmodule

// File: rtl/pt_count_core.sv
module pt_count_core
   import playtime_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode_i,
   input  logic             tick,
   input  logic             commit,
   input  logic [CNT_W-1:0] commit_value,
   input  logic             adj_load,
   input  logic [CNT_W-1:0] adj_value,
   output logic [CNT_W-1:0] count_o
);
   play_mode_e mode, prev_q;
   logic [CNT_W-1:0] count_q;
   logic start;

   assign mode    = play_mode_e'(mode_i);
   assign start   = (prev_q == PM_STOP) && (mode == PM_PLAY);
   assign count_o = count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= PM_STOP;
         count_q <= '0;
      end else begin
         prev_q <= mode;
         if (commit)                        count_q <= commit_value;
         else if (adj_load)                 count_q <= adj_value;
         else if (start)                    count_q <= '0;
         else if (tick && mode == PM_PLAY)  count_q <= count_q + 1'b1;
      end
   end
endmodule

// File: rtl/playtime_ms.sv
module playtime_ms #(
   parameter int CNT_W    = 24,
   parameter int BYTE_W   = 8,
   parameter int TICK_DIV = 100000,
   localparam int NBYTES  = CNT_W / BYTE_W,
   localparam int IDX_W   = $clog2(NBYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_i,
   input  logic [IDX_W-1:0]  host_sel,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [BYTE_W-1:0] host_wdata,
   output logic [BYTE_W-1:0] host_rdata,
   input  logic              adj_load,
   input  logic [CNT_W-1:0]  adj_value
);
   generate
      if (CNT_W % BYTE_W != 0) begin : g_bad_width
         $error("CNT_W must be a whole number of bytes");
      end
      if (NBYTES < 2) begin : g_bad_count
         $error("at least two byte registers are required");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
   endgenerate

   logic             ms_tick;
   logic             commit;
   logic [CNT_W-1:0] commit_value;
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] shadow_q;

   pt_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick)
   );

   pt_host_port #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_host (
      .clk(clk), .rst_n(rst_n), .sel(host_sel), .rd(host_rd), .wr(host_wr),
      .wdata(host_wdata), .count_i(count_q), .rdata(host_rdata),
      .commit(commit), .commit_value(commit_value), .shadow_o(shadow_q)
   );

   pt_count_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .tick(ms_tick),
      .commit(commit), .commit_value(commit_value),
      .adj_load(adj_load), .adj_value(adj_value), .count_o(count_q)
   );
endmodule

// File: rtl/playtime_ms_chk.sv
module playtime_ms_chk #(
   parameter int CNT_W  = 24,
   parameter int BYTE_W = 8,
   parameter int IDX_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode_i,
   input logic [IDX_W-1:0]  host_sel,
   input logic              host_rd,
   input logic              host_wr,
   input logic [BYTE_W-1:0] host_wdata,
   input logic              adj_load,
   input logic [CNT_W-1:0]  adj_value,
   input logic              ms_tick,
   input logic [CNT_W-1:0]  count_q,
   input logic [CNT_W-1:0]  shadow_q
);
   localparam int NBYTES = CNT_W / BYTE_W;
   logic past_valid;
   logic hi_wr;

   assign hi_wr = host_wr && (host_sel == IDX_W'(NBYTES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_valid <= 1'b0;
      else        past_valid <= 1'b1;
   end

   // R1 and R2: a play tick with no load and no clear adds one, modulo 2^CNT_W
   p_tick_incr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && ms_tick && mode_i == 2'd1 && $past(mode_i) != 2'd0 && !hi_wr && !adj_load)
      |=> count_q == CNT_W'($past(count_q) + 1'b1));

   p_shadow_only_on_low_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_rd && host_sel == IDX_W'(0)) |=> $stable(shadow_q));

   p_low_read_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_sel == IDX_W'(0)) |=> shadow_q == $past(count_q));

   p_stop_to_play_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && $past(mode_i) == 2'd0 && mode_i == 2'd1 && !hi_wr && !adj_load)
      |=> count_q == '0);

   p_hold_when_not_playing_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i != 2'd1 && !hi_wr && !adj_load) |=> $stable(count_q));

   p_adjust_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (adj_load && !hi_wr) |=> count_q == $past(adj_value));

   p_commit_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hi_wr |=> count_q[CNT_W-1 -: BYTE_W] == $past(host_wdata));
endmodule

bind playtime_ms playtime_ms_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .host_sel(host_sel),
   .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
   .adj_load(adj_load), .adj_value(adj_value), .ms_tick(ms_tick),
   .count_q(count_q), .shadow_q(shadow_q)
);

// File: tb/playtime_ms_test.sv
`timescale 1ns/1ps
module playtime_ms_test;
   localparam int DIV = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode_i = 2'd0;
   logic [1:0]  host_sel = 2'd0;
   logic        host_rd = 1'b0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_wdata = 8'h00;
   logic [7:0]  host_rdata;
   logic        adj_load = 1'b0;
   logic [23:0] adj_value = 24'h0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   playtime_ms #(.TICK_DIV(DIV)) uut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .host_sel(host_sel),
      .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .adj_load(adj_load), .adj_value(adj_value)
   );

   task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic host_write(input logic [1:0] idx, input logic [7:0] val);
      @(negedge clk);
      host_sel = idx; host_wdata = val; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic write_time(input logic [23:0] v);
      host_write(2'd0, v[7:0]);
      host_write(2'd1, v[15:8]);
      host_write(2'd2, v[23:16]);
   endtask

   task automatic read_time(output logic [23:0] v);
      @(negedge clk);
      host_sel = 2'd0; host_rd = 1'b1;
      #1 v[7:0] = host_rdata;
      @(negedge clk);
      host_rd = 1'b0; host_sel = 2'd1;
      #1 v[15:8] = host_rdata;
      host_sel = 2'd2;
      #1 v[23:16] = host_rdata;
   endtask

   task automatic set_mode(input logic [1:0] m);
      @(negedge clk);
      mode_i = m;
   endtask

   task automatic t_reset;
      logic [23:0] v;
      host_sel = 2'd1;
      #1 check("R10 shadow byte after reset", {16'h0, host_rdata}, 24'h0);
      read_time(v);
      check("R10 count after reset", v, 24'h0);
   endtask

   task automatic t_tick_rate;
      logic [23:0] v;
      set_mode(2'd2);
      write_time(24'h000010);
      @(negedge clk); mode_i = 2'd1;
      repeat (5 * DIV) @(negedge clk);
      mode_i = 2'd2;
      read_time(v);
      check("R1 five ticks from pause-resume", v, 24'h000015);
   endtask

   task automatic t_wrap;
      logic [23:0] v;
      write_time(24'hFFFFFF);
      @(negedge clk); mode_i = 2'd1;
      repeat (DIV) @(negedge clk);
      mode_i = 2'd2;
      read_time(v);
      check("R2 wrap FFFFFF to 0", v, 24'h000000);
   endtask

   task automatic t_coherent_read;
      logic [23:0] v;
      logic [7:0] lo;
      write_time(24'h12FFFF);
      @(negedge clk); host_sel = 2'd0; host_rd = 1'b1;
      #1 lo = host_rdata;
      @(negedge clk); host_rd = 1'b0; mode_i = 2'd1;
      repeat (2 * DIV) @(negedge clk);
      mode_i = 2'd2;
      check("R3 live low byte", {16'h0, lo}, 24'h0000FF);
      host_sel = 2'd1;
      #1 check("R3 middle byte from shadow", {16'h0, host_rdata}, 24'h0000FF);
      host_sel = 2'd2;
      #1 check("R3 high byte from shadow", {16'h0, host_rdata}, 24'h000012);
      read_time(v);
      check("R3 fresh read after ticks", v, 24'h130001);
   endtask

   task automatic t_staged_write;
      logic [23:0] v;
      host_write(2'd0, 8'hAA);
      host_write(2'd1, 8'hBB);
      read_time(v);
      check("R4 staged bytes leave count unchanged", v, 24'h130001);
      host_write(2'd2, 8'hCC);
      read_time(v);
      check("R4 high write commits all bytes", v, 24'hCCBBAA);
   endtask

   task automatic t_stop_play;
      logic [23:0] v;
      write_time(24'h00ABCD);
      set_mode(2'd0);
      repeat (3 * DIV) @(negedge clk);
      read_time(v);
      check("R6 stop holds count", v, 24'h00ABCD);
      @(negedge clk); mode_i = 2'd1;
      @(negedge clk); mode_i = 2'd2;
      read_time(v);
      check("R5 stop-to-play clears", v, 24'h000000);
   endtask

   task automatic t_hold;
      logic [23:0] v;
      write_time(24'h00ABCD);
      repeat (6 * DIV) @(negedge clk);
      read_time(v);
      check("R6 pause holds count", v, 24'h00ABCD);
      set_mode(2'd3);
      repeat (6 * DIV) @(negedge clk);
      read_time(v);
      check("R6 seek holds count", v, 24'h00ABCD);
   endtask

   task automatic t_adjust;
      logic [23:0] v;
      @(negedge clk); adj_value = 24'h345678; adj_load = 1'b1;
      @(negedge clk); adj_load = 1'b0;
      read_time(v);
      check("R7 adjust load in seek", v, 24'h345678);
   endtask

   task automatic t_priority;
      logic [23:0] v;
      set_mode(2'd2);
      host_write(2'd0, 8'h11);
      host_write(2'd1, 8'h22);
      @(negedge clk);
      host_sel = 2'd2; host_wdata = 8'h33; host_wr = 1'b1;
      adj_value = 24'h999999; adj_load = 1'b1;
      @(negedge clk); host_wr = 1'b0; adj_load = 1'b0;
      read_time(v);
      check("R8 commit wins over adjust", v, 24'h332211);
      set_mode(2'd0);
      host_write(2'd0, 8'h44);
      host_write(2'd1, 8'h55);
      @(negedge clk);
      mode_i = 2'd1; host_sel = 2'd2; host_wdata = 8'h66; host_wr = 1'b1;
      @(negedge clk); host_wr = 1'b0; mode_i = 2'd2;
      read_time(v);
      check("R9 commit wins over stop-to-play clear", v, 24'h665544);
   endtask

   task automatic t_out_of_range;
      logic [23:0] v;
      host_write(2'd3, 8'h77);
      host_sel = 2'd3;
      #1 check("R11 out-of-range read is zero", {16'h0, host_rdata}, 24'h0);
      read_time(v);
      check("R11 out-of-range write ignored", v, 24'h665544);
      host_write(2'd2, 8'h01);
      read_time(v);
      check("R11 staging untouched by out-of-range write", v, 24'h015544);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_tick_rate();
      t_wrap();
      t_coherent_read();
      t_staged_write();
      t_stop_play();
      set_mode(2'd2);
      t_hold();
      t_adjust();
      t_priority();
      t_out_of_range();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule